// File: doc/BRIEF.md
# Host Byte-Port Register Interface

This block sits on the host side of a parallel link between an 8-bit host processor and a DSP core. A 3-bit host address selects one of eight byte locations. These are a control byte, a command vector, a status byte, an interrupt vector byte, two locations that always read as zero, and two data byte lanes. A control bit chooses which of the two data addresses carries the high half of the 16-bit transfer word. The host reaches the locations through a chip select, a read strobe and a write strobe. Writes take effect on the rising clock edge. Read data is registered.

The host can post a command by writing a 7-bit vector with the pending bit set. The block then holds an interrupt request with that vector toward the core until the core acknowledges it. Two handshake flags are provided. One flag shows that the host may write a new word. The other shows that a word from the core is waiting to be read. A host can poll these flags or wire them to an interrupt.

When the core asserts its stop input, every host access is ignored. All host-side state keeps its value until stop is released.

Top module: `hostreg_port`

## Requirements
- R1: Address 0 (control, reset 0x00) and address 3 (interrupt vector, reset 0x0F) are read/write bytes that read back the last value written. Control bit 0 selects the data byte order.
- R2: Addresses 4 and 5 always read 0x00, and writes to them have no effect.
- R3: With control bit 0 clear, address 6 is the high byte and address 7 is the low byte of the 16-bit word, for both writes and reads. With the bit set, address 6 is the low byte and address 7 is the high byte.
- R4: A write to address 1 stores bits 6:0 as the vector and bit 7 as the pending flag. From the next cycle, `core_irq_o` equals the pending flag and `core_vec_o` equals the vector.
- R5: While the pending flag is set, writes to address 1 are ignored. A read of address 1 returns {pending, vector}.
- R6: A `core_ack_i` pulse clears the pending flag on the next cycle and leaves the vector unchanged.
- R7: A host write to address 6 alone does not change the transfer state. A write to address 7 completes the word: `core_tx_word_o` takes the new word, and the transmit-empty flag and `hreq_o` go low on the next cycle.
- R8: A `core_rx_rd_i` pulse sets transmit-empty and `hreq_o` again on the next cycle.
- R9: A `core_tx_wr_i` pulse loads the receive word and raises receive-full and `hack_o` on the next cycle. A host read of address 7 clears them.
- R10: Address 2 reads {5'b0, pending, transmit-empty, receive-full} (bit 0 = receive-full, bit 1 = transmit-empty, bit 2 = pending). It is read-only, and writes to it have no effect.
- R11: While `stop_i` is high, host writes, host reads and read side effects are all ignored, and `hdout_o` holds its value.
- R12: Host strobes have no effect while `hcs_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Core stop; host port disabled while high |
| hcs_i | input | 1 | Host chip select |
| hrd_i | input | 1 | Host read strobe |
| hwr_i | input | 1 | Host write strobe |
| haddr_i | input | 3 | Host byte address |
| hdin_i | input | 8 | Host write data |
| hdout_o | output | 8 | Registered host read data |
| hreq_o | output | 1 | Host may write (transmit empty) |
| hack_o | output | 1 | Receive word waiting |
| core_irq_o | output | 1 | Host command interrupt request |
| core_vec_o | output | 7 | Host command vector |
| core_ack_i | input | 1 | Core acknowledge of host command |
| core_tx_word_o | output | 16 | Word written by the host |
| core_rx_rd_i | input | 1 | Core has taken the host word |
| core_tx_wr_i | input | 1 | Core loads a word for the host |
| core_tx_word_i | input | 16 | Word from the core |

## Verification
Every result of this block appears exactly one clock edge after its cause. This holds for read data after a strobed read, for the handshake flags and transfer word after a data-lane write or a core pulse, and for the interrupt request after a command write or acknowledge. The bench drives each stimulus at a falling edge and holds it across exactly one rising edge. It samples at the following falling edge, which is the first point where the registered result is valid and the first point where a wrong flop count would show. Checks that a stimulus was ignored read the affected register back through the normal host read path before the next stimulus.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_IVEC = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_LANEA = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_LANEB = 3'd7;
  localparam logic [BYTE_W-1:0] IVEC_RST = 8'h0F;

  typedef struct packed {
    logic [4:0] rsvd;
    logic       cmd_busy;
    logic       tx_empty;
    logic       rx_full;
  } stat_t;
endpackage

// File: rtl/hostreg_cmd.sv
module hostreg_cmd #(
  parameter int VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [VEC_W:0]   wdata,
  input  logic             ack,
  output logic             pending,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      vec     <= '0;
    end else if (pending) begin
      if (ack) pending <= 1'b0;
    end else if (wr_en) begin
      pending <= wdata[VEC_W];
      vec     <= wdata[VEC_W-1:0];
    end
  end
endmodule

// File: rtl/hostreg_xfer.sv
module hostreg_xfer #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          little,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [BW-1:0] wdata,
  input  logic          rd_b,
  input  logic          core_rd,
  input  logic          core_wr,
  input  logic [2*BW-1:0] core_word,
  output logic [2*BW-1:0] tx_word,
  output logic [BW-1:0] lane_a,
  output logic [BW-1:0] lane_b,
  output logic          tx_empty,
  output logic          rx_full
);
  logic [BW-1:0]   hold_lo, hold_hi;
  logic [2*BW-1:0] rx_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_lo  <= '0;
      hold_hi  <= '0;
      tx_word  <= '0;
      tx_empty <= 1'b1;
    end else begin
      if (wr_a) begin
        if (little) hold_lo <= wdata;
        else        hold_hi <= wdata;
      end
      if (wr_b) begin
        tx_word  <= little ? {wdata, hold_lo} : {hold_hi, wdata};
        tx_empty <= 1'b0;
      end else if (core_rd) begin
        tx_empty <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
      rx_full <= 1'b0;
    end else if (core_wr) begin
      rx_word <= core_word;
      rx_full <= 1'b1;
    end else if (rd_b) begin
      rx_full <= 1'b0;
    end
  end

  assign lane_a = little ? rx_word[BW-1:0] : rx_word[2*BW-1:BW];
  assign lane_b = little ? rx_word[2*BW-1:BW] : rx_word[BW-1:0];
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
  import hostreg_pkg::*;
#(
  parameter int VEC_W = 7,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_i,
  input  logic              hcs_i,
  input  logic              hrd_i,
  input  logic              hwr_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [BYTE_W-1:0] hdin_i,
  output logic [BYTE_W-1:0] hdout_o,
  output logic              hreq_o,
  output logic              hack_o,
  output logic              core_irq_o,
  output logic [VEC_W-1:0]  core_vec_o,
  input  logic              core_ack_i,
  output logic [WORD_W-1:0] core_tx_word_o,
  input  logic              core_rx_rd_i,
  input  logic              core_tx_wr_i,
  input  logic [WORD_W-1:0] core_tx_word_i
);
  logic              acc, wr_en, rd_en;
  logic [BYTE_W-1:0] ctrl_q, ivec_q, rdata;
  logic [BYTE_W-1:0] lane_a, lane_b;
  logic              tx_empty, rx_full;
  stat_t             stat;

  assign acc   = hcs_i & ~stop_i;
  assign wr_en = acc & hwr_i;
  assign rd_en = acc & hrd_i & ~hwr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ivec_q <= IVEC_RST;
    end else if (wr_en) begin
      if (haddr_i == OFS_CTRL) ctrl_q <= hdin_i;
      if (haddr_i == OFS_IVEC) ivec_q <= hdin_i;
    end
  end

  hostreg_cmd #(.VEC_W(VEC_W)) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en && haddr_i == OFS_CMD),
    .wdata   (hdin_i[VEC_W:0]),
    .ack     (core_ack_i),
    .pending (core_irq_o),
    .vec     (core_vec_o)
  );

  hostreg_xfer #(.BW(BYTE_W)) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .little    (ctrl_q[0]),
    .wr_a      (wr_en && haddr_i == OFS_LANEA),
    .wr_b      (wr_en && haddr_i == OFS_LANEB),
    .wdata     (hdin_i),
    .rd_b      (rd_en && haddr_i == OFS_LANEB),
    .core_rd   (core_rx_rd_i),
    .core_wr   (core_tx_wr_i),
    .core_word (core_tx_word_i),
    .tx_word   (core_tx_word_o),
    .lane_a    (lane_a),
    .lane_b    (lane_b),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full)
  );

  assign hreq_o = tx_empty;
  assign hack_o = rx_full;

  always_comb begin
    stat          = '0;
    stat.cmd_busy = core_irq_o;
    stat.tx_empty = tx_empty;
    stat.rx_full  = rx_full;
  end

  always_comb begin
    unique case (haddr_i)
      OFS_CTRL:  rdata = ctrl_q;
      OFS_CMD:   rdata = {{(BYTE_W-VEC_W-1){1'b0}}, core_irq_o, core_vec_o};
      OFS_STAT:  rdata = stat;
      OFS_IVEC:  rdata = ivec_q;
      OFS_LANEA: rdata = lane_a;
      OFS_LANEB: rdata = lane_b;
      default:   rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        hdout_o <= '0;
    else if (rd_en) hdout_o <= rdata;
  end
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk #(
  parameter int VEC_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_i,
  input logic             hcs_i,
  input logic             hrd_i,
  input logic             hwr_i,
  input logic [2:0]       haddr_i,
  input logic [7:0]       hdout_o,
  input logic             hreq_o,
  input logic             hack_o,
  input logic             core_irq_o,
  input logic [VEC_W-1:0] core_vec_o,
  input logic             core_ack_i,
  input logic             core_rx_rd_i,
  input logic             core_tx_wr_i
);
  logic lane_b_wr;
  assign lane_b_wr = hcs_i && hwr_i && !stop_i && haddr_i == 3'd7;

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    core_irq_o && core_ack_i |=> !core_irq_o);

  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    core_irq_o && !core_ack_i |=> core_irq_o && $stable(core_vec_o));

  // R11
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> $stable(hdout_o));

  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hcs_i && hrd_i && !hwr_i && !stop_i && haddr_i[2:1] == 2'b10 |=> hdout_o == 8'h00);

  // R8
  tx_free_chk: assert property (@(posedge clk) disable iff (rst)
    core_rx_rd_i && !lane_b_wr |=> hreq_o);

  // R9
  rx_set_chk: assert property (@(posedge clk) disable iff (rst)
    core_tx_wr_i |=> hack_o);
endmodule

bind hostreg_port hostreg_port_chk #(.VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stop_i       (stop_i),
  .hcs_i        (hcs_i),
  .hrd_i        (hrd_i),
  .hwr_i        (hwr_i),
  .haddr_i      (haddr_i),
  .hdout_o      (hdout_o),
  .hreq_o       (hreq_o),
  .hack_o       (hack_o),
  .core_irq_o   (core_irq_o),
  .core_vec_o   (core_vec_o),
  .core_ack_i   (core_ack_i),
  .core_rx_rd_i (core_rx_rd_i),
  .core_tx_wr_i (core_tx_wr_i)
);

// File: tb/hostreg_port_bench.sv
module hostreg_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stop_i = 1'b0;
  logic        hcs_i = 1'b0, hrd_i = 1'b0, hwr_i = 1'b0;
  logic [2:0]  haddr_i = '0;
  logic [7:0]  hdin_i = '0;
  logic [7:0]  hdout_o;
  logic        hreq_o, hack_o, core_irq_o;
  logic [6:0]  core_vec_o;
  logic        core_ack_i = 1'b0, core_rx_rd_i = 1'b0, core_tx_wr_i = 1'b0;
  logic [15:0] core_tx_word_o;
  logic [15:0] core_tx_word_i = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  hostreg_port u_hostreg_port (
    .clk(clk), .rst(rst), .stop_i(stop_i), .hcs_i(hcs_i), .hrd_i(hrd_i),
    .hwr_i(hwr_i), .haddr_i(haddr_i), .hdin_i(hdin_i), .hdout_o(hdout_o),
    .hreq_o(hreq_o), .hack_o(hack_o), .core_irq_o(core_irq_o),
    .core_vec_o(core_vec_o), .core_ack_i(core_ack_i),
    .core_tx_word_o(core_tx_word_o), .core_rx_rd_i(core_rx_rd_i),
    .core_tx_wr_i(core_tx_wr_i), .core_tx_word_i(core_tx_word_i)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [2:0] a, logic [7:0] d, logic cs = 1'b1);
    @(negedge clk);
    hcs_i = cs; hwr_i = 1'b1; haddr_i = a; hdin_i = d;
    @(negedge clk);
    hcs_i = 1'b0; hwr_i = 1'b0;
  endtask

  task automatic hread(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hcs_i = 1'b1; hrd_i = 1'b1; haddr_i = a;
    @(negedge clk);
    d = hdout_o;
    hcs_i = 1'b0; hrd_i = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); core_ack_i = 1'b1;
    @(negedge clk); core_ack_i = 1'b0;
  endtask

  task automatic pulse_core_rd();
    @(negedge clk); core_rx_rd_i = 1'b1;
    @(negedge clk); core_rx_rd_i = 1'b0;
  endtask

  task automatic push_word(logic [15:0] w);
    @(negedge clk); core_tx_wr_i = 1'b1; core_tx_word_i = w;
    @(negedge clk); core_tx_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R7 hreq reset", hreq_o, 1);
    check("R9 hack reset", hack_o, 0);
    check("R4 irq reset", core_irq_o, 0);
    hread(3'd0, d); check("R1 ctrl reset", d, 8'h00);
    hread(3'd3, d); check("R1 ivec reset", d, 8'h0F);
    hread(3'd2, d); check("R10 status reset", d, 8'h02);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    hwrite(3'd0, 8'h5A); hread(3'd0, d); check("R1 ctrl rw", d, 8'h5A);
    hwrite(3'd3, 8'h81); hread(3'd3, d); check("R1 ivec rw", d, 8'h81);
    hwrite(3'd0, 8'h00);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    hwrite(3'd4, 8'hFF); hwrite(3'd5, 8'hA5);
    hread(3'd4, d); check("R2 addr4", d, 8'h00);
    hread(3'd5, d); check("R2 addr5", d, 8'h00);
  endtask

  task automatic t_cmd();
    logic [7:0] d;
    hwrite(3'd1, 8'hA5);
    check("R4 irq raised", core_irq_o, 1);
    check("R4 vector", core_vec_o, 7'h25);
    hread(3'd2, d); check("R10 status pending", d, 8'h06);
    hwrite(3'd1, 8'h8F);
    hread(3'd1, d); check("R5 write ignored", d, 8'hA5);
    check("R5 vec held", core_vec_o, 7'h25);
    pulse_ack();
    check("R6 irq cleared", core_irq_o, 0);
    hread(3'd1, d); check("R6 vector kept", d, 8'h25);
    hwrite(3'd1, 8'h11);
    check("R4 no pending", core_irq_o, 0);
    check("R4 vector only", core_vec_o, 7'h11);
  endtask

  task automatic t_tx_big();
    logic [7:0] d;
    hwrite(3'd6, 8'hAB);
    check("R7 lane a no commit", hreq_o, 1);
    hwrite(3'd7, 8'hCD);
    check("R7 hreq low", hreq_o, 0);
    check("R3 big word", core_tx_word_o, 16'hABCD);
    hread(3'd2, d); check("R10 status full", d, 8'h00);
    pulse_core_rd();
    check("R8 hreq back", hreq_o, 1);
  endtask

  task automatic t_tx_little();
    hwrite(3'd0, 8'h01);
    hwrite(3'd6, 8'h12); hwrite(3'd7, 8'h34);
    check("R3 little word", core_tx_word_o, 16'h3412);
    pulse_core_rd();
  endtask

  task automatic t_rx();
    logic [7:0] d;
    push_word(16'hBEEF);
    check("R9 hack set", hack_o, 1);
    hread(3'd6, d); check("R3 little lane a", d, 8'hEF);
    check("R9 lane a keeps full", hack_o, 1);
    hread(3'd7, d); check("R3 little lane b", d, 8'hBE);
    check("R9 hack cleared", hack_o, 0);
    hwrite(3'd0, 8'h00);
    push_word(16'h1357);
    hread(3'd6, d); check("R3 big lane a", d, 8'h13);
    hread(3'd2, d); check("R10 status rx", d, 8'h03);
    hread(3'd7, d); check("R3 big lane b", d, 8'h57);
    hwrite(3'd2, 8'hFF);
    hread(3'd2, d); check("R10 write ignored", d, 8'h02);
  endtask

  task automatic t_stop();
    logic [7:0] d;
    hread(3'd3, d);
    @(negedge clk); stop_i = 1'b1;
    hwrite(3'd3, 8'h33);
    hwrite(3'd1, 8'h87);
    check("R11 no cmd", core_irq_o, 0);
    push_word(16'h2468);
    hread(3'd7, d); check("R11 hdout held", d, 8'h81);
    check("R11 no rx clear", hack_o, 1);
    @(negedge clk); stop_i = 1'b0;
    hread(3'd3, d); check("R11 ivec kept", d, 8'h81);
    hread(3'd7, d); check("R11 word kept", d, 8'h68);
  endtask

  task automatic t_cs();
    logic [7:0] d;
    hwrite(3'd3, 8'h44, 1'b0);
    hread(3'd3, d); check("R12 no cs write", d, 8'h81);
    hwrite(3'd1, 8'hC2, 1'b0);
    check("R12 no cs cmd", core_irq_o, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unused();
    t_cmd();
    t_tx_big();
    t_tx_little();
    t_rx();
    t_stop();
    t_cs();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      summary();
    end
  end
endmodule